// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is the target side of a two-wire SMBus-style serial link. It gives a host read and write access to a small bank of 8-bit configuration registers that drive clock-control logic. The bus lines are brought into the system clock domain through two-flop synchronizers. START and STOP are recognised as SDA edges while SCL is high. The target pulls SDA low only to acknowledge or to send a 0 data bit, and it changes SDA only while SCL is low.

A transfer is indexed. The host writes the target's address and a starting register index. For a write, the host then sends a byte count followed by that many data bytes, and they land in consecutive registers. For a read, the host issues a repeated START and the read address. The target then returns a byte count first, followed by register contents from the index upward, until the host refuses a byte.

Three fields of the bank are also presented as decoded outputs. The 14-bit spread code spans two adjacent registers. Two 4-bit divider selects share one register.

Top module: `smb_regbank_tgt`

## Requirements
- R1: After reset every register reads 0x00, `spread_code`, `ddr_div_sel` and `cpu_div_sel` are 0, and `sda_oe` is 0.
- R2: The address bytes 0xD2 (write) and 0xD3 (read) are acknowledged by holding SDA low during the ninth clock. Any other address is refused with SDA left high, and the following bytes are neither acknowledged nor stored until the next START.
- R3: A write sends the index N, then the count X, then X data bytes. Each of these bytes is acknowledged, and data byte k is stored in register N+k once its eighth bit has been sampled.
- R4: Data bytes sent after X bytes have been stored are refused, and they change no register.
- R5: Data bytes aimed at an index of 24 or above are acknowledged and discarded, and they leave the 24 registers unchanged.
- R6: After 0xD2, N, a repeated START and 0xD3, the target sends max(24−N, 0) first, then register N, N+1, and so on, MSB first. Positions at index 24 or above read 0x00.
- R7: After the host refuses a read byte, the target keeps SDA released for all further clocks until the next START or STOP.
- R8: A START or STOP that arrives part-way through a byte abandons that byte and returns the target to idle with SDA released. Bytes already completed keep their stored values.
- R9: Register 14 bits 7:6 always read 0. `spread_code` is {register 14 bits 5:0, register 13}.
- R10: Register 15 drives `ddr_div_sel` from bits 7:4 and `cpu_div_sel` from bits 3:0.
- R11: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_bank | output | NUM_REGS*8 | All registers, register i at bits 8i+7:8i |
| spread_code | output | 14 | Spread-spectrum code from registers 13 and 14 |
| ddr_div_sel | output | 4 | DDR divider select |
| cpu_div_sel | output | 4 | CPU divider select |

## Verification
A wrong index or count shows up on `cfg_bank` by the end of the byte that follows, either as a value in the wrong register or as a register that did not change. On a read it shows up in the count byte that comes straight after the read address. A state machine that fails to leave a refused or aborted transfer shows up on the very next ninth clock as an unexpected acknowledge, or as the target holding SDA low while the host clocks out 0xFF. A bit-counter slip corrupts the first byte it touches, and because every byte is compared it is caught within one byte time.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_INDEX,
    RL_COUNT,
    RL_DATA
  } smb_role_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  // two-flop synchronizers plus one history stage; bus idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int          NUM_REGS  = 24,
  parameter int          RSVD_IDX  = 14,
  parameter logic [7:0]  RSVD_MASK = 8'h3F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] bank
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] MASK = (i == RSVD_IDX) ? RSVD_MASK : 8'hFF;
    logic [7:0] q;
    logic       hit;
    assign hit = wr_en && (wr_idx == 8'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data & MASK;
    end
    assign bank[i*8 +: 8] = q;
  end

  // out-of-range indices read as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == 8'(i)) rd_data = bank[i*8 +: 8];
    end
  end
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 24,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] idx,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};
  localparam logic [7:0] NUM8    = 8'(NUM_REGS);

  smb_state_e st_q, st_d;
  smb_role_e  role_q, role_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] idx_q, idx_d;
  logic [7:0] cnt_q, cnt_d;
  logic       ack_q, ack_d;
  logic       tx_q, tx_d;
  logic       hack_q, hack_d;
  logic [7:0] rx_byte;
  logic [7:0] remain;

  assign rx_byte = {sh_q[6:0], sda_s};
  assign remain  = (idx_q < NUM8) ? (NUM8 - idx_q) : 8'h00;

  always_comb begin
    st_d   = st_q;
    role_d = role_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    ack_d  = ack_q;
    tx_d   = tx_q;
    hack_d = hack_q;
    wr_en  = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
    end else if (start_det) begin
      st_d   = ST_RX;
      role_d = RL_ADDR;
      bit_d  = '0;
    end else begin
      case (st_q)
        ST_RX: if (scl_rise) begin
          sh_d = rx_byte;
          if (bit_q == 3'd7) begin
            st_d  = ST_RX_END;
            ack_d = 1'b1;
            case (role_q)
              RL_ADDR: begin
                if (rx_byte == WR_BYTE) begin
                  tx_d   = 1'b0;
                  role_d = RL_INDEX;
                end else if (rx_byte == RD_BYTE) begin
                  tx_d = 1'b1;
                end else begin
                  ack_d = 1'b0;
                end
              end
              RL_INDEX: begin
                idx_d  = rx_byte;
                role_d = RL_COUNT;
              end
              RL_COUNT: begin
                cnt_d  = rx_byte;
                role_d = RL_DATA;
              end
              default: begin
                if (cnt_q != 8'h00) begin
                  wr_en = 1'b1;
                  idx_d = idx_q + 8'd1;
                  cnt_d = cnt_q - 8'd1;
                end else begin
                  ack_d = 1'b0;
                end
              end
            endcase
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
        ST_RX_END: if (scl_fall) begin
          st_d = ack_q ? ST_RX_ACK : ST_IDLE;
        end
        ST_RX_ACK: if (scl_fall) begin
          bit_d = '0;
          if (tx_q) begin
            st_d = ST_TX;
            sh_d = remain;
          end else begin
            st_d = ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_q == 3'd7) begin
            st_d   = ST_TX_ACK;
            hack_d = 1'b0;
          end else begin
            bit_d = bit_q + 3'd1;
            sh_d  = {sh_q[6:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) hack_d = ~sda_s;
          if (scl_fall) begin
            if (hack_q) begin
              st_d  = ST_TX;
              bit_d = '0;
              sh_d  = rd_data;
              idx_d = idx_q + 8'd1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      role_q <= RL_ADDR;
      bit_q  <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      tx_q   <= 1'b0;
      hack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      role_q <= role_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
      tx_q   <= tx_d;
      hack_q <= hack_d;
    end
  end

  assign idx     = idx_q;
  assign wr_data = rx_byte;
  assign sda_oe  = (st_q == ST_RX_ACK) || ((st_q == ST_TX) && !sh_q[7]);
endmodule

// File: rtl/smb_regbank_tgt.sv
module smb_regbank_tgt #(
  parameter int         NUM_REGS  = 24,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         SS_LO_IDX = 13,
  parameter int         DIV_IDX   = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_bank,
  output logic [13:0]           spread_code,
  output logic [3:0]            ddr_div_sel,
  output logic [3:0]            cpu_div_sel
);
  localparam int SS_HI_IDX = SS_LO_IDX + 1;

  logic [1:0] rst_ff;
  logic       rst_sync_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] idx, wr_data, rd_data;
  logic       wr_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  smb_sync i_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) i_engine (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .idx(idx), .wr_en(wr_en), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  smb_regfile #(.NUM_REGS(NUM_REGS), .RSVD_IDX(SS_HI_IDX), .RSVD_MASK(8'h3F)) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(idx),
    .wr_data(wr_data), .rd_idx(idx), .rd_data(rd_data), .bank(cfg_bank)
  );

  assign spread_code = {cfg_bank[SS_HI_IDX*8 +: 6], cfg_bank[SS_LO_IDX*8 +: 8]};
  assign ddr_div_sel = cfg_bank[DIV_IDX*8+4 +: 4];
  assign cpu_div_sel = cfg_bank[DIV_IDX*8 +: 4];
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk #(
  parameter int NUM_REGS = 24,
  parameter int RSVD_IDX = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg_bank
);
  // R11: data line is only moved while the clock is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s) || $past(start_det) || $past(stop_det));

  // R3: the bank only changes just after a sampled clock-high
  p_bank_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bank) |-> $past(scl_s));

  // R8: bus conditions leave the line released
  p_release_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  p_release_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R9: reserved bits stay clear
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bank[RSVD_IDX*8+6 +: 2] == 2'b00);
endmodule

bind smb_regbank_tgt smb_regbank_chk #(.NUM_REGS(NUM_REGS), .RSVD_IDX(SS_HI_IDX)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .cfg_bank(cfg_bank)
);

// File: tb/test_smb_regbank_tgt.sv
module test_smb_regbank_tgt;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 24;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic host_scl, host_sda;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_bank;
  logic [13:0] spread_code;
  logic [3:0] ddr_div_sel, cpu_div_sel;
  logic sda_line;
  int n_chk = 0, n_fail = 0;
  logic [7:0] shadow [NREG];
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  assign sda_line = host_sda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  smb_regbank_tgt i_smb_regbank_tgt (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_bank(cfg_bank), .spread_code(spread_code),
    .ddr_div_sel(ddr_div_sel), .cpu_div_sel(cpu_div_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R11: the target moves SDA only while the host holds SCL low
  always @(negedge clk) begin
    if (rst_n && !done && sda_oe != prev_oe) chk(!host_scl, "R11 oe edge with scl high", 1, 0);
    prev_oe = sda_oe;
  end

  task automatic b_start();
    host_sda = 1; host_scl = 1; wt(W); host_sda = 0; wt(W); host_scl = 0; wt(W);
  endtask
  task automatic b_rstart();
    host_sda = 1; wt(W); host_scl = 1; wt(W); host_sda = 0; wt(W); host_scl = 0; wt(W);
  endtask
  task automatic b_stop();
    host_sda = 0; wt(W); host_scl = 1; wt(W); host_sda = 1; wt(W);
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; wt(W); host_scl = 1; wt(W); host_scl = 0;
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    host_sda = 1; wt(W); host_scl = 1; wt(W); acked = !sda_line; host_scl = 0;
  endtask
  task automatic recv_byte(output logic [7:0] b, input bit ack);
    b = '0;
    host_sda = 1;
    for (int i = 0; i < 8; i++) begin
      wt(W); host_scl = 1; wt(W); b = {b[6:0], sda_line}; host_scl = 0;
    end
    host_sda = ack ? 1'b0 : 1'b1; wt(W); host_scl = 1; wt(W); host_scl = 0;
  endtask

  function automatic logic [7:0] bank_at(input int i);
    return cfg_bank[i*8 +: 8];
  endfunction
  function automatic logic [7:0] wmask(input int i);
    return (i == 14) ? 8'h3F : 8'hFF;
  endfunction

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(bank_at(i) == shadow[i], req, bank_at(i), shadow[i]);
  endtask

  // write X bytes from index n; extra bytes beyond count are expected refused (R4)
  task automatic blk_write(input int n, input int x, input logic [7:0] d [], input string req);
    bit a;
    b_start();
    send_byte(8'hD2, a); chk(a, "R2 write address ack", a, 1);
    send_byte(8'(n), a); chk(a, "R3 index ack", a, 1);
    send_byte(8'(x), a); chk(a, "R3 count ack", a, 1);
    for (int k = 0; k < d.size(); k++) begin
      send_byte(d[k], a);
      chk(a == (k < x), req, a, int'(k < x));
      if (k < x && n + k < NREG) shadow[n+k] = d[k] & wmask(n + k);
    end
    b_stop();
  endtask

  task automatic blk_read(input int n, input int ndata);
    bit a;
    logic [7:0] b, exp;
    int xc;
    xc = (n < NREG) ? NREG - n : 0;
    b_start();
    send_byte(8'hD2, a); chk(a, "R2 write address ack", a, 1);
    send_byte(8'(n), a); chk(a, "R3 index ack", a, 1);
    b_rstart();
    send_byte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    recv_byte(b, ndata > 0); chk(b == 8'(xc), "R6 count byte", b, xc);
    for (int k = 0; k < ndata; k++) begin
      recv_byte(b, k < ndata - 1);
      exp = (n + k < NREG) ? shadow[n+k] : 8'h00;
      chk(b == exp, "R6 read data", b, exp);
    end
    recv_byte(b, 1'b0); chk(b == 8'hFF, "R7 released after NAK", b, 8'hFF);
    b_stop();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit a;
    logic [7:0] d [];
    host_scl = 1; host_sda = 1; rst_n = 0;
    for (int i = 0; i < NREG; i++) shadow[i] = 8'h00;
    wt(5); rst_n = 1; wt(10);

    // R1 reset state
    chk(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
    chk(cfg_bank == '0, "R1 bank zero", 0, 0);
    chk(spread_code == 0 && ddr_div_sel == 0 && cpu_div_sel == 0, "R1 decoded fields", spread_code, 0);

    // R3 full-bank write with an arithmetic pattern
    d = new[NREG];
    for (int i = 0; i < NREG; i++) d[i] = 8'((i * 37 + 5) & 8'hFF);
    blk_write(0, NREG, d, "R3 data ack");
    check_bank("R3 bank after write");
    chk(spread_code == {shadow[14][5:0], shadow[13]}, "R9 spread code", spread_code, {shadow[14][5:0], shadow[13]});
    chk(bank_at(14)[7:6] == 2'b00, "R9 reserved bits", bank_at(14), shadow[14]);

    // R6 R7 read sweep over every start index, including past the end
    for (int n = 0; n <= NREG + 1; n++) blk_read(n, (n < NREG) ? NREG - n : 0);
    // R6 read running beyond the bank returns zeros
    blk_read(22, 4);

    // R5 write straddling the end of the bank
    d = new[6];
    for (int k = 0; k < 6; k++) d[k] = 8'hA0 + 8'(k);
    blk_write(20, 6, d, "R5 ack beyond bank");
    check_bank("R5 bank after straddle");

    // R4 more bytes than the count
    d = new[2]; d[0] = 8'h11; d[1] = 8'h22;
    blk_write(2, 1, d, "R4 extra byte refused");
    check_bank("R4 bank after extra byte");

    // R2 address mismatch
    b_start();
    send_byte(8'hA4, a); chk(!a, "R2 foreign address nak", a, 0);
    send_byte(8'h03, a); chk(!a, "R2 idle after mismatch", a, 0);
    send_byte(8'h55, a); chk(!a, "R2 idle after mismatch", a, 0);
    b_stop();
    check_bank("R2 bank after mismatch");

    // R8 abort by STOP mid-byte
    b_start();
    send_byte(8'hD2, a); send_byte(8'd6, a); send_byte(8'd3, a);
    send_byte(8'h77, a); chk(a, "R8 first byte ack", a, 1); shadow[6] = 8'h77;
    send_bits(8'h88, 4);
    b_stop();
    check_bank("R8 bank after stop abort");
    chk(sda_oe == 0, "R8 released after abort", sda_oe, 0);

    // R8 abort by repeated START mid-byte
    b_start();
    send_byte(8'hD2, a); send_byte(8'd9, a); send_byte(8'd2, a);
    send_byte(8'h99, a); chk(a, "R8 first byte ack", a, 1); shadow[9] = 8'h99;
    send_bits(8'h40, 3);
    host_scl = 0; b_rstart();
    send_byte(8'hD2, a); chk(a, "R8 address after restart", a, 1);
    b_stop();
    check_bank("R8 bank after start abort");

    // R9 reserved bits and spread code halves
    d = new[2]; d[0] = 8'h12; d[1] = 8'hFF;
    blk_write(13, 2, d, "R9 write ack");
    chk(bank_at(14) == 8'h3F, "R9 reserved masked", bank_at(14), 8'h3F);
    chk(spread_code == 14'h3F12, "R9 spread code", spread_code, 14'h3F12);
    blk_read(13, 2);

    // R10 divider nibble split sweep
    d = new[1];
    for (int k = 0; k < 16; k++) begin
      d[0] = 8'(k * 16 + (15 - k));
      blk_write(15, 1, d, "R10 write ack");
      chk(ddr_div_sel == 4'(k), "R10 ddr select", ddr_div_sel, k);
      chk(cpu_div_sel == 4'(15 - k), "R10 cpu select", cpu_div_sel, 15 - k);
    end
    check_bank("R10 bank after sweep");

    finish_run();
  end
endmodule